// File: doc/BRIEF.md
# Ethernet Transmit Status and Abort Monitor

This block sits beside an Ethernet transmit MAC and follows each frame from start to finish. When a frame starts, it classifies the destination address as broadcast or multicast. While the frame is in progress, it counts collisions, tracks how far transmission has progressed against a collision window, and times carrier deferral in nibble times at the selected link speed. When the frame ends, it delivers a status word that records either a clean send or the reason the frame was dropped.

An abort can have one of four causes: a collision past the window, a collision count above the retry limit, deferral held too long, or a starved transmit FIFO. Any abort latches a sticky halt, and further frame starts are refused while it is set. The abort also raises a transmit-error interrupt flag. Both flags stay set until software pulses a write-one-to-clear input. All MAC events arrive as single-cycle strobes.

Top module: `tx_stat_abort`

## Requirements
- R1: After reset, status_o, halted_o, txerr_irq_o and stat_vld_o are 0. status_o[31:16] always reads 0.
- R2: When done_i arrives in an active frame with no abort, status_o[15] is set and stat_vld_o pulses for one cycle, one cycle after the done_i cycle.
- R3: At an accepted frame start, dest_i is classified. All 48 ones sets status bit 14 (broadcast). Otherwise dest_i[40], which is bit 0 of the first octet dest_i[47:40], sets bit 13 (multicast). The two bits are never set together.
- R4: A collision while the count of byte_tick_i since the last xmit_start_i or collision exceeds coll_win_i aborts the frame and sets bit 12.
- R5: The collision count resets at frame start. A collision that brings the count above retry_lim_i aborts the frame in that same cycle and sets bit 10, unless R4 applies to that collision.
- R6: Nibble ticks counted while defer_i is high abort the frame and set bit 11 on the tick after 6071 of them when speed100_i=1, or after 24287 of them when speed100_i=0. The count resets at xmit_start_i.
- R7: While def_dis_i=1, deferral never aborts the frame.
- R8: underrun_i in an active frame aborts it and sets bit 9.
- R9: Every abort sets halted_o and txerr_irq_o in the cycle that status_o is written. While halted_o=1, frame_start_i is ignored.
- R10: clr_halt_i clears halted_o and txerr_irq_o. If an abort falls in the same cycle as clr_halt_i, the abort wins.
- R11: When an abort and done_i fall in the same cycle, only the abort is reported and bit 15 stays 0.
- R12: An accepted frame start clears status_o[15:9] on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start_i | input | 1 | New frame strobe |
| dest_i | input | 48 | Destination address, first octet in [47:40] |
| xmit_start_i | input | 1 | Transmission (re)begins after deferral or backoff |
| byte_tick_i | input | 1 | One byte sent |
| nib_tick_i | input | 1 | One nibble time elapsed |
| defer_i | input | 1 | Deferring to carrier |
| coll_i | input | 1 | Collision strobe |
| underrun_i | input | 1 | Transmit FIFO underrun strobe |
| done_i | input | 1 | Frame delivered and FIFO drained |
| coll_win_i | input | 6 | Collision window in bytes |
| retry_lim_i | input | 4 | Maximum collisions allowed |
| speed100_i | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| def_dis_i | input | 1 | 1 = never abort on deferral |
| clr_halt_i | input | 1 | Write-one-to-clear pulse for halt and interrupt |
| status_o | output | 32 | Frame status word |
| stat_vld_o | output | 1 | Status word updated |
| halted_o | output | 1 | Sticky halt |
| txerr_irq_o | output | 1 | Transmit-error interrupt flag |

## Verification
Two pairs of events can land in the same cycle. An abort can coincide with the software clear: the bench drives underrun_i and clr_halt_i on the same edge and expects halted_o and txerr_irq_o to stay set. A late collision can coincide with done_i: the scoreboard expects a word carrying only the abort bit and no clean-send bit. Both deferral thresholds are probed at the count that must not abort and at the next count that must.

// File: rtl/tx_stat_abort.sv
module tx_stat_abort #(
  parameter int CW_W     = 6,
  parameter int RL_W     = 4,
  parameter int POS_W    = 8,
  parameter int LIM_FAST = 6071,
  parameter int LIM_SLOW = 24287
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  input  logic [47:0]      dest_i,
  input  logic             xmit_start_i,
  input  logic             byte_tick_i,
  input  logic             nib_tick_i,
  input  logic             defer_i,
  input  logic             coll_i,
  input  logic             underrun_i,
  input  logic             done_i,
  input  logic [CW_W-1:0]  coll_win_i,
  input  logic [RL_W-1:0]  retry_lim_i,
  input  logic             speed100_i,
  input  logic             def_dis_i,
  input  logic             clr_halt_i,
  output logic [31:0]      status_o,
  output logic             stat_vld_o,
  output logic             halted_o,
  output logic             txerr_irq_o
);
  localparam int DW  = $clog2(LIM_SLOW + 1) + 1;
  localparam int CCW = RL_W + 1;
  localparam logic [DW-1:0] LF = DW'(LIM_FAST);
  localparam logic [DW-1:0] LS = DW'(LIM_SLOW);

  logic            busy, bc_q, mc_q;
  logic [6:0]      st_q;
  logic [CCW-1:0]  coll_cnt;
  logic [POS_W-1:0] pos_cnt;
  logic [DW-1:0]   def_cnt;

  wire start_ok = frame_start_i && !halted_o;
  wire bcast    = &dest_i;
  wire mcast    = dest_i[40] && !bcast;
  wire act      = busy && !start_ok;

  wire [CCW-1:0]  coll_nxt = coll_cnt + 1'b1;
  wire [DW-1:0]   def_lim  = speed100_i ? LF : LS;
  wire [POS_W-1:0] win_ext = {{(POS_W-CW_W){1'b0}}, coll_win_i};

  wire late  = act && coll_i && (pos_cnt > win_ext);
  wire xcol  = act && coll_i && !late && (coll_nxt > {1'b0, retry_lim_i});
  wire xdef  = act && defer_i && nib_tick_i && !def_dis_i && (def_cnt >= def_lim);
  wire urun  = act && underrun_i;
  wire abort = late || xcol || xdef || urun;
  wire fin_ok = act && done_i && !abort;
  wire fin   = abort || fin_ok;

  assign status_o = {16'h0, st_q, 9'h0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      bc_q <= 1'b0;
      mc_q <= 1'b0;
      st_q <= '0;
      stat_vld_o <= 1'b0;
    end else begin
      stat_vld_o <= fin;
      if (start_ok) begin
        busy <= 1'b1;
        bc_q <= bcast;
        mc_q <= mcast;
        st_q <= '0;
      end else if (fin) begin
        busy <= 1'b0;
        st_q <= {fin_ok, bc_q, mc_q, late, xdef, xcol, urun};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll_cnt <= '0;
      pos_cnt  <= '0;
      def_cnt  <= '0;
    end else begin
      if (start_ok)
        coll_cnt <= '0;
      else if (act && coll_i)
        coll_cnt <= coll_nxt;

      if (start_ok || xmit_start_i || coll_i)
        pos_cnt <= '0;
      else if (act && byte_tick_i && !(&pos_cnt))
        pos_cnt <= pos_cnt + 1'b1;

      if (start_ok || xmit_start_i || fin)
        def_cnt <= '0;
      else if (act && defer_i && nib_tick_i && !(&def_cnt))
        def_cnt <= def_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_o    <= 1'b0;
      txerr_irq_o <= 1'b0;
    end else if (abort) begin
      halted_o    <= 1'b1;
      txerr_irq_o <= 1'b1;
    end else if (clr_halt_i) begin
      halted_o    <= 1'b0;
      txerr_irq_o <= 1'b0;
    end
  end
endmodule

module tx_stat_abort_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_start_i,
  input logic        clr_halt_i,
  input logic [31:0] status_o,
  input logic        stat_vld_o,
  input logic        halted_o,
  input logic        txerr_irq_o
);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[31:16] == 16'h0);
  a_r2_ok_excludes_abort: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld_o |-> !(status_o[15] && |status_o[12:9]));
  a_r3_cast_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_o[14] && status_o[13]));
  a_r9_abort_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld_o && |status_o[12:9]) |-> (halted_o && txerr_irq_o));
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && !clr_halt_i) |=> halted_o);
  a_r12_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && !halted_o) |=> (status_o[15:9] == 7'h0 && !stat_vld_o));
endmodule

bind tx_stat_abort tx_stat_abort_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
  .clr_halt_i(clr_halt_i), .status_o(status_o), .stat_vld_o(stat_vld_o),
  .halted_o(halted_o), .txerr_irq_o(txerr_irq_o)
);

// File: tb/tx_stat_abort_tb_top.sv
module tx_stat_abort_tb_top;
  logic clk = 0, rst_n = 0;
  logic frame_start_i = 0, xmit_start_i = 0, byte_tick_i = 0, nib_tick_i = 0;
  logic defer_i = 0, coll_i = 0, underrun_i = 0, done_i = 0;
  logic speed100_i = 1, def_dis_i = 0, clr_halt_i = 0;
  logic [47:0] dest_i = '0;
  logic [5:0] coll_win_i = 6'd4;
  logic [3:0] retry_lim_i = 4'd2;
  logic [31:0] status_o;
  logic stat_vld_o, halted_o, txerr_irq_o;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC = 48'h0100_5E00_0001;
  localparam logic [47:0] UC = 48'h0012_3456_789A;

  always #2.5 clk = ~clk;

  tx_stat_abort dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic [31:0] e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) if (rst_n && stat_vld_o) begin
    if (exp_q.size() == 0) chk("unexpected status", status_o, 32'hDEAD);
    else chk(tag_q.pop_front(), status_o, exp_q.pop_front());
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic [47:0] d);
    frame_start_i = 1; dest_i = d; cyc();
    frame_start_i = 0; xmit_start_i = 1; cyc();
    xmit_start_i = 0;
  endtask

  task automatic clear();
    clr_halt_i = 1; cyc(); clr_halt_i = 0; cyc();
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    cyc(3);
    chk("R1 reset status", status_o, 0);
    chk("R1 reset flags", {halted_o, txerr_irq_o, stat_vld_o}, 0);
    rst_n = 1; cyc(2);

    // R2/R3 clean sends with each address class
    start(UC); byte_tick_i = 1; cyc(10); byte_tick_i = 0;
    push("R2 ok unicast", 32'h8000); done_i = 1; cyc(); done_i = 0; cyc(2);
    start(BC); push("R3 broadcast", 32'hC000); done_i = 1; cyc(); done_i = 0; cyc(2);
    start(MC); push("R3 multicast", 32'hA000); done_i = 1; cyc(); done_i = 0; cyc(2);

    // R12 start clears previous word
    frame_start_i = 1; dest_i = UC; cyc(); frame_start_i = 0; cyc();
    chk("R12 cleared", status_o, 0);
    done_i = 1; push("R2 ok after clear", 32'h8000); cyc(); done_i = 0; cyc(2);

    // R4 late collision
    coll_win_i = 6'd4;
    start(BC); byte_tick_i = 1; cyc(6); byte_tick_i = 0;
    push("R4 late collision", 32'h5000); coll_i = 1; cyc(); coll_i = 0; cyc();
    chk("R9 halt and irq", {halted_o, txerr_irq_o}, 2'b11);
    // R9 start ignored while halted
    frame_start_i = 1; dest_i = UC; cyc(); frame_start_i = 0; done_i = 1; cyc(); done_i = 0; cyc(2);
    chk("R9 start ignored", status_o, 32'h5000);
    clear();
    chk("R10 cleared flags", {halted_o, txerr_irq_o}, 2'b00);

    // R5 excessive collisions, window wide
    coll_win_i = 6'd8; retry_lim_i = 4'd2;
    start(MC);
    coll_i = 1; cyc(); coll_i = 0; xmit_start_i = 1; cyc(); xmit_start_i = 0;
    coll_i = 1; cyc(); coll_i = 0; xmit_start_i = 1; cyc(); xmit_start_i = 0; cyc();
    chk("R5 retries within limit", {halted_o, stat_vld_o}, 2'b00);
    push("R5 excessive collisions", 32'h2400); coll_i = 1; cyc(); coll_i = 0; cyc();
    clear();

    // R6 deferral at 100 Mbps
    speed100_i = 1; def_dis_i = 0;
    frame_start_i = 1; dest_i = UC; cyc(); frame_start_i = 0;
    defer_i = 1; nib_tick_i = 1; cyc(6071); nib_tick_i = 0; cyc();
    chk("R6 fast at limit no abort", {halted_o, status_o[11]}, 2'b00);
    nib_tick_i = 1; push("R6 fast deferral", 32'h0800); cyc(); nib_tick_i = 0; defer_i = 0; cyc();
    clear();

    // R6 deferral at 10 Mbps
    speed100_i = 0;
    frame_start_i = 1; dest_i = BC; cyc(); frame_start_i = 0;
    defer_i = 1; nib_tick_i = 1; cyc(24287); nib_tick_i = 0; cyc();
    chk("R6 slow at limit no abort", {halted_o, status_o[11]}, 2'b00);
    nib_tick_i = 1; push("R6 slow deferral", 32'h4800); cyc(); nib_tick_i = 0; defer_i = 0; cyc();
    clear();

    // R7 disable
    def_dis_i = 1; speed100_i = 1;
    frame_start_i = 1; dest_i = UC; cyc(); frame_start_i = 0;
    defer_i = 1; nib_tick_i = 1; cyc(7000); nib_tick_i = 0; defer_i = 0; cyc();
    chk("R7 no deferral abort", {halted_o, status_o[11]}, 2'b00);
    xmit_start_i = 1; cyc(); xmit_start_i = 0;
    push("R7 frame completes", 32'h8000); done_i = 1; cyc(); done_i = 0; cyc(2);
    def_dis_i = 0;

    // R8 underrun plus R10 clear in same cycle
    start(MC);
    underrun_i = 1; clr_halt_i = 1; push("R8 underrun", 32'h2200); cyc();
    underrun_i = 0; clr_halt_i = 0; cyc();
    chk("R10 abort beats clear", {halted_o, txerr_irq_o}, 2'b11);
    clear();

    // R11 abort and done together
    coll_win_i = 6'd4;
    start(UC); byte_tick_i = 1; cyc(6); byte_tick_i = 0;
    coll_i = 1; done_i = 1; push("R11 abort over done", 32'h1000); cyc();
    coll_i = 0; done_i = 0; cyc(2);
    chk("R1 upper bits", {16'h0, status_o[31:16]}, 0);
    clear();

    chk("scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule